// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes the byte stream of an incoming Ethernet frame and stores it into receive buffers of 128 bytes each. A small internal table of descriptors, held in flops, describes those buffers. Every descriptor has two 32-bit words. The address word holds the buffer start address together with two flag bits. The status word is written back by the block. The block walks the table one buffer at a time. When a frame is longer than one buffer, it continues into the next descriptor. When it finishes a buffer, it marks that buffer as used and records where the frame starts, where it ends, and how long it is.

Software sets up the ring and returns buffers through a descriptor access port. A separate base register says where the ring starts. A descriptor whose wrap flag is set sends the walk back to that base.

Frames arrive on a valid/ready byte stream whose last beat is flagged. The block accepts one byte per cycle. Back-pressure follows one rule: `s_ready` is low in exactly the cycles in which software writes a descriptor word. Software therefore always wins the descriptor table, and the stream waits one cycle for each such write. Accepted bytes leave on a plain buffer write port.

The match flags on the stream are produced by an address filter outside this block. They are sampled on the last beat of the frame.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset, `s_ready` is 1, `buf_we` and `ovf` are 0, and every descriptor word reads back as zero.
- R2: A software write updates the chosen word: `sw_sel` 0 selects the address word and 1 selects the status word. A read with `sw_re` returns that word on `sw_rdata` in the cycle after the request.
- R3: Each accepted byte is written one cycle later to buffer address (address word with bits [1:0] cleared) + byte offset, with the offset running from 0 to 127. A frame longer than 128 bytes continues in the next descriptor of the ring.
- R4: The status word of a filled buffer carries bit 14 if the buffer holds the first byte of the frame, bit 15 if it holds the last byte, and in bits [11:0] the total frame length on the end buffer and zero on every other buffer.
- R5: When a buffer is completed, bit 0 (used) of its address word is set, and the address and bit 1 are kept unchanged.
- R6: After a descriptor whose address-word bit 1 (wrap) is set, the next buffer is the descriptor at the ring base. Without that bit, the walk goes to the next index, which is taken modulo the ring size.
- R7: Only on the end buffer, the status word carries `s_bcast` in bit 31, `s_hit[k]` in bit 23+k and `s_type_hit` in bit 22, all sampled on the last beat. These bits are zero on every other buffer.
- R8: If the descriptor at the pointer is already used when a frame's first byte arrives, the block drops the whole frame. It makes no buffer write and no descriptor write, the pointer stays where it is, and `ovf` pulses for one cycle, one cycle after that byte.
- R9: If a later buffer of a frame finds its descriptor used, the rest of the frame is dropped and `ovf` pulses once. Buffers already written are kept without an end flag, and the next frame starts at that same descriptor.
- R10: `s_ready` is 0 in exactly the cycles where `sw_we` is 1, and no byte is accepted in such a cycle.
- R11: Writing `base_idx` with `base_we` sets the ring base and moves the current pointer to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software descriptor word write |
| sw_re | input | 1 | Software descriptor word read request |
| sw_sel | input | 1 | Word select: 0 address word, 1 status word |
| sw_idx | input | 5 | Descriptor index for software access |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Read data, one cycle after `sw_re` |
| base_we | input | 1 | Load ring base and pointer |
| base_idx | input | 5 | Ring base index |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when high with `s_valid` |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of the frame |
| s_bcast | input | 1 | Broadcast destination flag, sampled on the last beat |
| s_hit | input | 4 | Specific address match flags, sampled on the last beat |
| s_type_hit | input | 1 | Type-ID match flag, sampled on the last beat |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_data | output | 8 | Buffer byte data |
| ovf | output | 1 | One-cycle pulse when a frame or its remainder is dropped |

## Verification
The bench follows the timing of each result.

- **Buffer writes** appear one cycle after the accepted beat. A monitor samples `buf_we` on the falling edge and compares it against a queue of expected addresses and bytes, which a bench model fills before each frame is driven.
- **`ovf` pulses** come one cycle after the blocked beat. They are counted on the falling edge and compared with the model's count two cycles after the frame ends.
- **Descriptor write-back** takes effect at the clock edge of the chunk's final beat. Words are read back through the software port and sampled on the falling edge after the read request.
- **`s_ready`** is combinational with `sw_we`. It is checked one time unit after the stall is driven, before the next rising edge.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  // Descriptor bit positions; software decodes these.
  localparam int unsigned AW_USED  = 0;
  localparam int unsigned AW_WRAP  = 1;
  localparam int unsigned ST_SOF   = 14;
  localparam int unsigned ST_EOF   = 15;
  localparam int unsigned ST_TYPE  = 22;
  localparam int unsigned ST_HIT0  = 23;
  localparam int unsigned ST_BCAST = 31;
  localparam int unsigned LEN_W    = 12;

  typedef struct packed {
    logic       bcast;
    logic [3:0] hit;
    logic       type_hit;
  } rxr_attr_t;

  function automatic logic [31:0] rxr_status(input logic sof, input logic eof,
                                             input logic [LEN_W-1:0] len,
                                             input rxr_attr_t a);
    logic [31:0] w;
    w = '0;
    w[LEN_W-1:0]        = len;
    w[ST_SOF]           = sof;
    w[ST_EOF]           = eof;
    w[ST_TYPE]          = a.type_hit;
    w[ST_HIT0 +: 4]     = a.hit;
    w[ST_BCAST]         = a.bcast;
    return w;
  endfunction
endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem #(
  parameter int unsigned NDESC = 32,
  localparam int unsigned IDX_W = $clog2(NDESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic             sw_re,
  input  logic             sw_sel,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [31:0]      sw_wdata,
  output logic [31:0]      sw_rdata,
  input  logic [IDX_W-1:0] hw_idx,
  output logic [31:0]      hw_addr_word,
  input  logic             hw_we,
  input  logic [31:0]      hw_addr_wdata,
  input  logic [31:0]      hw_stat_wdata
);
  logic [31:0] addr_q [NDESC];
  logic [31:0] stat_q [NDESC];

  assign hw_addr_word = addr_q[hw_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) begin
        addr_q[i] <= '0;
        stat_q[i] <= '0;
      end
      sw_rdata <= '0;
    end else begin
      for (int i = 0; i < NDESC; i++) begin
        if (hw_we && hw_idx == IDX_W'(i)) begin
          addr_q[i] <= hw_addr_wdata;
          stat_q[i] <= hw_stat_wdata;
        end else if (sw_we && sw_idx == IDX_W'(i)) begin
          if (sw_sel) stat_q[i] <= sw_wdata;
          else        addr_q[i] <= sw_wdata;
        end
      end
      if (sw_re) sw_rdata <= sw_sel ? stat_q[sw_idx] : addr_q[sw_idx];
    end
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_we && sw_we)); // R10
  AST_FREE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    hw_we |-> !addr_q[hw_idx][rxr_pkg::AW_USED]); // R8
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int unsigned NDESC = 32,
  localparam int unsigned IDX_W = $clog2(NDESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [IDX_W-1:0] base_idx,
  input  logic             adv,
  input  logic             wrap_flag,
  output logic [IDX_W-1:0] cur_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NDESC - 1);
  logic [IDX_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      cur_idx <= '0;
    end else if (base_we) begin
      base_q  <= base_idx;
      cur_idx <= base_idx;
    end else if (adv) begin
      if (wrap_flag)            cur_idx <= base_q;
      else if (cur_idx == LAST) cur_idx <= '0;
      else                      cur_idx <= cur_idx + 1'b1;
    end
  end
endmodule

// File: rtl/rxr_fill_ctl.sv
module rxr_fill_ctl
  import rxr_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 128,
  localparam int unsigned OFF_W = $clog2(BUF_BYTES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beat,
  input  logic [7:0]  s_data,
  input  logic        s_last,
  input  rxr_attr_t   attr,
  input  logic [31:0] cur_addr_word,
  output logic        hw_we,
  output logic [31:0] hw_addr_wdata,
  output logic [31:0] hw_stat_wdata,
  output logic        buf_we,
  output logic [31:0] buf_addr,
  output logic [7:0]  buf_data,
  output logic        ovf
);
  localparam logic [OFF_W-1:0] OFF_END = OFF_W'(BUF_BYTES - 1);

  logic [OFF_W-1:0] off_q;
  logic [LEN_W-1:0] flen_q, len_now;
  logic             first_q, drop_q;
  logic             chunk_start, blocked, take, chunk_full;
  logic [31:0]      buf_base;

  assign chunk_start = beat && !drop_q && off_q == '0;
  assign blocked     = chunk_start && cur_addr_word[AW_USED];
  assign take        = beat && !drop_q && !blocked;
  assign chunk_full  = off_q == OFF_END;
  assign len_now     = flen_q + 1'b1;
  assign buf_base    = {cur_addr_word[31:2], 2'b00};

  always_comb begin
    hw_we                  = take && (s_last || chunk_full);
    hw_addr_wdata          = cur_addr_word;
    hw_addr_wdata[AW_USED] = 1'b1;
    hw_stat_wdata          = rxr_status(first_q, s_last,
                                        s_last ? len_now : '0,
                                        s_last ? attr : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q    <= '0;
      flen_q   <= '0;
      first_q  <= 1'b1;
      drop_q   <= 1'b0;
      buf_we   <= 1'b0;
      buf_addr <= '0;
      buf_data <= '0;
      ovf      <= 1'b0;
    end else begin
      buf_we <= take;
      ovf    <= blocked;
      if (take) begin
        buf_addr <= buf_base + 32'(off_q);
        buf_data <= s_data;
      end
      if (beat) begin
        if (s_last) begin
          off_q   <= '0;
          flen_q  <= '0;
          first_q <= 1'b1;
          drop_q  <= 1'b0;
        end else if (drop_q || blocked) begin
          drop_q  <= 1'b1;
        end else begin
          flen_q  <= len_now;
          off_q   <= chunk_full ? '0 : off_q + 1'b1;
          if (chunk_full) first_q <= 1'b0;
        end
      end
    end
  end

  AST_MID_LEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_we && !hw_stat_wdata[ST_EOF]) |->
      (hw_stat_wdata[LEN_W-1:0] == '0 && hw_stat_wdata[31:ST_TYPE] == '0)); // R4
  AST_END_LEN_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_we && hw_stat_wdata[ST_EOF]) |-> hw_stat_wdata[LEN_W-1:0] != '0); // R4
  AST_FULL_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_we && !hw_stat_wdata[ST_EOF]) |-> off_q == OFF_END); // R3
  AST_OVF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> !$past(hw_we)); // R8
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer #(
  parameter int unsigned NDESC     = 32,
  parameter int unsigned BUF_BYTES = 128,
  localparam int unsigned IDX_W    = $clog2(NDESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic             sw_re,
  input  logic             sw_sel,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [31:0]      sw_wdata,
  output logic [31:0]      sw_rdata,
  input  logic             base_we,
  input  logic [IDX_W-1:0] base_idx,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  input  logic             s_bcast,
  input  logic [3:0]       s_hit,
  input  logic             s_type_hit,
  output logic             buf_we,
  output logic [31:0]      buf_addr,
  output logic [7:0]       buf_data,
  output logic             ovf
);
  import rxr_pkg::*;

  logic [IDX_W-1:0] cur_idx;
  logic [31:0]      cur_addr_word, hw_addr_wdata, hw_stat_wdata;
  logic             hw_we, beat;
  rxr_attr_t        attr;

  assign s_ready = !sw_we;
  assign beat    = s_valid && s_ready;
  assign attr    = '{bcast: s_bcast, hit: s_hit, type_hit: s_type_hit};

  rxr_desc_mem #(.NDESC(NDESC)) u_mem (
    .clk, .rst_n, .sw_we, .sw_re, .sw_sel, .sw_idx, .sw_wdata, .sw_rdata,
    .hw_idx(cur_idx), .hw_addr_word(cur_addr_word), .hw_we,
    .hw_addr_wdata, .hw_stat_wdata
  );

  rxr_ring_ptr #(.NDESC(NDESC)) u_ptr (
    .clk, .rst_n, .base_we, .base_idx, .adv(hw_we),
    .wrap_flag(cur_addr_word[AW_WRAP]), .cur_idx
  );

  rxr_fill_ctl #(.BUF_BYTES(BUF_BYTES)) u_fill (
    .clk, .rst_n, .beat, .s_data, .s_last, .attr, .cur_addr_word,
    .hw_we, .hw_addr_wdata, .hw_stat_wdata, .buf_we, .buf_addr, .buf_data, .ovf
  );
endmodule

// File: tb/rxr_ring_writer_tb.sv
module rxr_ring_writer_tb;
  localparam int N = 32;
  localparam int BB = 128;

  logic clk = 0, rst_n = 0;
  logic sw_we = 0, sw_re = 0, sw_sel = 0, base_we = 0;
  logic [4:0] sw_idx = 0, base_idx = 0;
  logic [31:0] sw_wdata = 0, sw_rdata, buf_addr;
  logic s_valid = 0, s_ready, s_last = 0, s_bcast = 0, s_type_hit = 0, buf_we, ovf;
  logic [7:0] s_data = 0, buf_data;
  logic [3:0] s_hit = 0;

  rxr_ring_writer u_dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, exp_ovf = 0, ovf_seen = 0, qh = 0, qt = 0;
  bit done = 0;
  logic [39:0] q [0:16383];
  logic [31:0] m_addr [N], m_stat [N];
  int m_base = 0, m_cur = 0;
  logic [7:0] fb [0:4095];

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_stat(input bit sof, input bit eof, input int len,
                                          input logic [5:0] fl);
    logic [31:0] w = 0;
    w[11:0] = 12'(len); w[14] = sof; w[15] = eof;
    if (eof) begin w[31] = fl[5]; w[26:23] = fl[4:1]; w[22] = fl[0]; end
    return w;
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (buf_we) begin
      if (qh == qt) chk("R3/R8 unexpected write", {buf_addr, buf_data}, 40'h0);
      else begin chk("R3", {buf_addr, buf_data}, q[qh]); qh++; end
    end
    if (ovf) ovf_seen++;
  end

  task automatic sw_write(input int idx, input bit sel, input logic [31:0] d);
    @(negedge clk); sw_we = 1; sw_sel = sel; sw_idx = 5'(idx); sw_wdata = d;
    @(negedge clk); sw_we = 0;
    if (sel) m_stat[idx] = d; else m_addr[idx] = d;
  endtask

  task automatic dump(input string req);
    for (int i = 0; i < N; i++)
      for (int s = 0; s < 2; s++) begin
        @(negedge clk); sw_re = 1; sw_sel = s[0]; sw_idx = 5'(i);
        @(negedge clk); sw_re = 0;
        chk(req, {8'h0, sw_rdata}, {8'h0, s ? m_stat[i] : m_addr[i]});
      end
  endtask

  task automatic set_base(input int idx);
    @(negedge clk); base_we = 1; base_idx = 5'(idx);
    @(negedge clk); base_we = 0;
    m_base = idx; m_cur = idx;
  endtask

  task automatic reclaim(input int keep_mod);
    for (int i = 0; i < N; i++)
      if (m_addr[i][0] && (keep_mod == 0 || ($urandom % keep_mod) != 0))
        sw_write(i, 0, m_addr[i] & ~32'h1);
  endtask

  // stall_at < 0: no software write during the frame
  task automatic send(input int len, input logic [5:0] fl, input int stall_at, input int stall_idx);
    int off = 0, flen = 0; bit first = 1, drop = 0, lst;
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    for (int i = 0; i < len; i++) begin
      lst = (i == len - 1);
      if (drop) begin if (lst) drop = 0; end
      else if (off == 0 && m_addr[m_cur][0]) begin exp_ovf++; drop = !lst; end
      else begin
        q[qt] = {({m_addr[m_cur][31:2], 2'b00} + 32'(off)), fb[i]}; qt++; flen++;
        if (lst || off == BB - 1) begin
          m_stat[m_cur] = mk_stat(first, lst, lst ? flen : 0, fl);
          m_addr[m_cur][0] = 1'b1;
          if (m_addr[m_cur][1]) m_cur = m_base; else m_cur = (m_cur + 1) % N;
          off = 0; first = 0;
        end else off++;
      end
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_valid = 1; s_data = fb[i]; s_last = (i == len - 1);
      {s_bcast, s_hit, s_type_hit} = (i == len - 1) ? fl : ~fl;
      if (i == stall_at) begin
        sw_we = 1; sw_sel = 1; sw_idx = 5'(stall_idx); sw_wdata = 32'hCAFE_0000 + 32'(i);
        #1 chk("R10 ready low", {39'h0, s_ready}, 40'h0);
        @(posedge clk); @(negedge clk); sw_we = 0;
        m_stat[stall_idx] = 32'hCAFE_0000 + 32'(i);
      end
      @(posedge clk);
    end
    @(negedge clk); s_valid = 0; s_last = 0;
    @(negedge clk); @(negedge clk);
    chk("R8/R9 ovf count", 40'(ovf_seen), 40'(exp_ovf));
    chk("R3 all bytes written", 40'(qh), 40'(qt));
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) begin m_addr[i] = 0; m_stat[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 ready", {39'h0, s_ready}, 40'h1);
    chk("R1 buf_we", {39'h0, buf_we}, 40'h0);
    chk("R1 ovf", {39'h0, ovf}, 40'h0);
    dump("R1");
    for (int i = 0; i < N; i++) begin
      sw_write(i, 0, 32'h2000_0000 + 32'(i * BB) | ((i == N - 1) ? 32'h2 : 32'h0));
      sw_write(i, 1, 32'h0);
    end
    dump("R2");
    send(128, 6'b100001, -1, 0);
    send(129, 6'b010100, -1, 0);
    send(1, 6'b001010, -1, 0);
    dump("R4/R5/R7");
    send(200, 6'b110011, 50, 30);          // R10
    dump("R10 write lands");
    for (int f = 0; f < 20; f++) begin     // R6 wraps 31->base 0 along the way
      reclaim(5);
      send(1 + int'($urandom % 350), 6'($urandom), -1, 0);
    end
    dump("R5/R6");
    // R8: descriptor at pointer used at frame start
    if (!m_addr[m_cur][0]) sw_write(m_cur, 0, m_addr[m_cur] | 32'h1);
    send(300, 6'b111111, -1, 0);
    reclaim(0);
    send(10, 6'b000001, -1, 0);
    // R11 base, R6 short ring 24..27, R9 mid-frame drop
    reclaim(0);
    set_base(24);
    sw_write(27, 0, m_addr[27] | 32'h2);
    send(600, 6'b100000, -1, 0);
    dump("R9/R11");
    reclaim(0);
    send(50, 6'b000110, -1, 0);
    dump("R6/R11");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule